// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 32-bit or 64-bit integer, signed or unsigned, into an IEEE 754 binary64 or binary32 value. The result is always delivered in the 64-bit register layout: a binary32 result is rounded at single precision first and then widened without loss. One normalising datapath serves all four source types and both result precisions. A leading-zero count aligns the magnitude, and two rounders sit side by side, one per precision.

Rounding follows a 2-bit mode input. Beside the value, the block returns the status fields an FP unit would merge into its status register: a 5-bit result class, a fraction-rounded bit, a fraction-inexact bit and a sticky inexact-exception request. A separate qualifier says whether those fields should be written at all. A 32-bit integer widened to binary64 can never round, so for that case the qualifier stays low. Results appear one clock after the input strobe.

Top module: `i2fConvert`

## Requirements
- R1: `srcType` selects the source: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. The 32-bit types use only `srcData[31:0]`, and the upper half has no effect on any output.
- R2: A negative signed source is converted by its magnitude and gets bit 63 of `result` set. Unsigned sources never produce a set bit 63.
- R3: A zero source yields `result` = 0 (+0.0). When status is written, `classCode` is 5'b00010 for that zero.
- R4: For source types 0 and 1 with `singleMode` = 0, `statusUpdate` is 0, and `classCode`, `fracRounded`, `fracInexact` and `inexactSet` are all 0.
- R5: For every other combination, `statusUpdate` is 1 and `classCode` is 5'b00100 for a positive nonzero result or 5'b01000 for a negative one.
- R6: With `singleMode` = 1 the value is rounded to a 24-bit significand and then widened to binary64: `result[28:0]` is zero and the exponent field is in binary64 bias.
- R7: `rndMode` 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 rounds toward +infinity, and 11 rounds toward -infinity.
- R8: `fracRounded` is 1 when the magnitude was incremented by rounding. `fracInexact` is 1 when discarded bits were nonzero. `inexactSet` equals `fracInexact`.
- R9: `outValid` rises exactly one clock after `inValid`, and the outputs hold between results. After reset, `outValid`, `result` and `statusUpdate` are 0.
- R10: A rounding carry out of the significand raises the exponent by one and clears the fraction. For example, unsigned 2^64-1 rounded to nearest gives 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: the source operands are valid this cycle |
| srcData | input | 64 | Integer source |
| srcType | input | 2 | Source type (see R1) |
| singleMode | input | 1 | 1 = binary32 result, 0 = binary64 result |
| rndMode | input | 2 | Rounding mode (see R7) |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 64 | Converted value in binary64 layout |
| classCode | output | 5 | Result class for the status register |
| fracRounded | output | 1 | Magnitude was incremented by rounding |
| fracInexact | output | 1 | Result is inexact |
| inexactSet | output | 1 | Request to set the sticky inexact exception |
| statusUpdate | output | 1 | Status fields are to be written |

## Verification
The assertions take for granted that `inValid` is low while reset is held, and that `srcType`, `singleMode` and `rndMode` are stable during the strobe cycle. They make no assumption about the upper half of `srcData` for 32-bit types. The stimulus changes every input only on the falling clock edge and keeps `inValid` low through reset. It deliberately puts random junk in the upper half of 32-bit sources. It also mixes small values, exact ties, values near powers of two and full-width random data, so that every rounding direction and every carry case is reached.

// File: rtl/i2fPkg.sv
package i2fPkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rndMode_e;

  localparam logic [4:0] CLS_NONE    = 5'b00000;
  localparam logic [4:0] CLS_POSZERO = 5'b00010;
  localparam logic [4:0] CLS_POSNORM = 5'b00100;
  localparam logic [4:0] CLS_NEGNORM = 5'b01000;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic statusEn;  // status fields are meaningful
  } cvtStrobe_t;

endpackage

// File: rtl/i2fLzc.sv
module i2fLzc #(
  parameter int W = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vecIn,
  output logic [CW-1:0] zeroCnt
);
  always_comb begin
    zeroCnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vecIn[i]) zeroCnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2fRound.sv
module i2fRound #(
  parameter int INT_W  = 64,
  parameter int FRAC_W = 52,
  localparam int NF    = INT_W - 1,
  localparam int GPOS  = NF - 1 - FRAC_W
) (
  input  logic [NF-1:0]     normFrac,
  input  logic              negative,
  input  logic [1:0]        rndMode,
  output logic [FRAC_W-1:0] fracOut,
  output logic              carryOut,
  output logic              incr,
  output logic              inexact
);
  import i2fPkg::*;

  logic [FRAC_W-1:0] keep;
  logic              guardBit;
  logic              stickyBit;
  logic [FRAC_W:0]   sumVal;

  assign keep      = normFrac[NF-1 -: FRAC_W];
  assign guardBit  = normFrac[GPOS];
  assign stickyBit = |normFrac[GPOS-1:0];
  assign inexact   = guardBit | stickyBit;

  always_comb begin
    unique case (rndMode_e'(rndMode))
      RM_NEAR: incr = guardBit & (stickyBit | keep[0]);
      RM_ZERO: incr = 1'b0;
      RM_UP:   incr = ~negative & inexact;
      RM_DOWN: incr = negative & inexact;
      default: incr = 1'b0;
    endcase
  end

  assign sumVal   = {1'b0, keep} + {{FRAC_W{1'b0}}, incr};
  assign carryOut = sumVal[FRAC_W];
  assign fracOut  = sumVal[FRAC_W-1:0];
endmodule

// File: rtl/i2fControl.sv
module i2fControl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                wideSrc,
  input  logic                singleMode,
  output i2fPkg::cvtStrobe_t  strobe,
  output logic                outValid,
  output logic                statusUpdate
);
  // a narrow source widened to double never rounds
  assign strobe.load     = inValid;
  assign strobe.statusEn = inValid & (wideSrc | singleMode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      statusUpdate <= 1'b0;
    end else begin
      outValid     <= inValid;
      statusUpdate <= strobe.load ? strobe.statusEn : statusUpdate;
    end
  end

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
endmodule

// File: rtl/i2fDatapath.sv
module i2fDatapath #(
  parameter int INT_W   = 64,
  parameter int EXP_W   = 11,
  parameter int DP_FRAC = 52,
  parameter int SP_FRAC = 23,
  parameter int BIAS    = 1023,
  localparam int HALF_W = INT_W / 2,
  localparam int LZ_W   = $clog2(INT_W) + 1,
  localparam int PAD_W  = DP_FRAC - SP_FRAC,
  localparam int EXP_TOP = BIAS + INT_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  i2fPkg::cvtStrobe_t strobe,
  input  logic [INT_W-1:0]   srcData,
  input  logic [1:0]         srcType,
  input  logic               singleMode,
  input  logic [1:0]         rndMode,
  output logic [INT_W-1:0]   resultQ,
  output logic [4:0]         classQ,
  output logic               roundedQ,
  output logic               inexactQ
);
  import i2fPkg::*;

  logic               isSigned;
  logic [INT_W-1:0]   extVal;
  logic               negative;
  logic [INT_W-1:0]   magVal;
  logic               isZero;
  logic [LZ_W-1:0]    lzCnt;
  logic [INT_W-2:0]   normFrac;

  logic [DP_FRAC-1:0] fracD;
  logic [SP_FRAC-1:0] fracS;
  logic               carryD, carryS, incD, incS, inxD, inxS;

  logic               carrySel, incSel, inxSel;
  logic [DP_FRAC-1:0] fracSel;
  logic [EXP_W-1:0]   expBiased;
  logic [INT_W-1:0]   resNext;
  logic [4:0]         clsNext;

  // source selection: narrow types read only the low half
  assign isSigned = ~srcType[0];
  always_comb begin
    if (srcType[1])    extVal = srcData;
    else if (isSigned) extVal = {{HALF_W{srcData[HALF_W-1]}}, srcData[HALF_W-1:0]};
    else               extVal = {{HALF_W{1'b0}}, srcData[HALF_W-1:0]};
  end

  assign negative = isSigned & extVal[INT_W-1];
  assign magVal   = negative ? (~extVal + 1'b1) : extVal;
  assign isZero   = (magVal == '0);

  i2fLzc #(.W(INT_W)) uLzc (
    .vecIn  (magVal),
    .zeroCnt(lzCnt)
  );

  // drop the hidden bit after aligning
  assign normFrac = (INT_W-1)'(magVal << lzCnt[LZ_W-2:0]);

  i2fRound #(.INT_W(INT_W), .FRAC_W(DP_FRAC)) uRndD (
    .normFrac(normFrac), .negative(negative), .rndMode(rndMode),
    .fracOut(fracD), .carryOut(carryD), .incr(incD), .inexact(inxD)
  );

  i2fRound #(.INT_W(INT_W), .FRAC_W(SP_FRAC)) uRndS (
    .normFrac(normFrac), .negative(negative), .rndMode(rndMode),
    .fracOut(fracS), .carryOut(carryS), .incr(incS), .inexact(inxS)
  );

  assign carrySel = singleMode ? carryS : carryD;
  assign incSel   = singleMode ? incS   : incD;
  assign inxSel   = singleMode ? inxS   : inxD;
  assign fracSel  = singleMode ? {fracS, {PAD_W{1'b0}}} : fracD;

  assign expBiased = EXP_W'(EXP_TOP) - EXP_W'(lzCnt) + EXP_W'(carrySel);

  assign resNext = isZero ? '0 : {negative, expBiased, fracSel};

  always_comb begin
    if (isZero)        clsNext = CLS_POSZERO;
    else if (negative) clsNext = CLS_NEGNORM;
    else               clsNext = CLS_POSNORM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ  <= '0;
      classQ   <= CLS_NONE;
      roundedQ <= 1'b0;
      inexactQ <= 1'b0;
    end else if (strobe.load) begin
      resultQ  <= resNext;
      classQ   <= strobe.statusEn ? clsNext : CLS_NONE;
      roundedQ <= strobe.statusEn & ~isZero & incSel;
      inexactQ <= strobe.statusEn & ~isZero & inxSel;
    end
  end

  // R2
  unsigned_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && srcType[0]) |=> !resultQ[INT_W-1]);

  // R6
  single_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && singleMode) |=> (resultQ[PAD_W-1:0] == '0));

  // R8
  rounded_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    roundedQ |-> inexactQ);
endmodule

// File: rtl/i2fConvert.sv
module i2fConvert #(
  parameter int INT_W   = 64,
  parameter int EXP_W   = 11,
  parameter int DP_FRAC = 52,
  parameter int SP_FRAC = 23,
  parameter int BIAS    = 1023
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [INT_W-1:0] srcData,
  input  logic [1:0]       srcType,
  input  logic             singleMode,
  input  logic [1:0]       rndMode,
  output logic             outValid,
  output logic [INT_W-1:0] result,
  output logic [4:0]       classCode,
  output logic             fracRounded,
  output logic             fracInexact,
  output logic             inexactSet,
  output logic             statusUpdate
);
  i2fPkg::cvtStrobe_t strobe;

  i2fControl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .wideSrc(srcType[1]), .singleMode(singleMode),
    .strobe(strobe), .outValid(outValid), .statusUpdate(statusUpdate)
  );

  i2fDatapath #(
    .INT_W(INT_W), .EXP_W(EXP_W), .DP_FRAC(DP_FRAC),
    .SP_FRAC(SP_FRAC), .BIAS(BIAS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcData(srcData),
    .srcType(srcType), .singleMode(singleMode), .rndMode(rndMode),
    .resultQ(result), .classQ(classCode),
    .roundedQ(fracRounded), .inexactQ(fracInexact)
  );

  assign inexactSet = fracInexact;

  // R4
  quiet_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !statusUpdate) |-> (classCode == 5'b0 && !fracRounded && !inexactSet));
endmodule

// File: tb/sim_i2fConvert.sv
`timescale 1ns/1ps
module sim_i2fConvert;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcData = '0;
  logic [1:0]  srcType = '0;
  logic        singleMode = 1'b0;
  logic [1:0]  rndMode = '0;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  classCode;
  logic        fracRounded, fracInexact, inexactSet, statusUpdate;

  int compared = 0;
  int mismatched = 0;
  bit allDone = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic [4:0]  cls;
    logic        rnd;
    logic        inx;
    logic        upd;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  i2fConvert u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcData(srcData),
    .srcType(srcType), .singleMode(singleMode), .rndMode(rndMode),
    .outValid(outValid), .result(result), .classCode(classCode),
    .fracRounded(fracRounded), .fracInexact(fracInexact),
    .inexactSet(inexactSet), .statusUpdate(statusUpdate)
  );

  // reference from the requirements: remainder compare, not shift-and-guard
  function automatic item_t refModel(input logic [63:0] d, input logic [1:0] t,
                                     input logic sgl, input logic [1:0] rm);
    item_t e;
    logic [63:0] ext, mag, kept, rem, half;
    logic neg, inexact, up;
    int p, prec, drop;
    logic [51:0] frac;
    if (t[1]) ext = d;
    else if (!t[0]) ext = {{32{d[31]}}, d[31:0]};
    else ext = {32'b0, d[31:0]};
    neg = !t[0] && ext[63];
    mag = neg ? -ext : ext;
    e.upd = t[1] | sgl;
    e.tag = "R5 R6 R7 R8 R10 model";
    if (mag == 0) begin
      e.res = '0; e.cls = 5'b00010; e.rnd = 0; e.inx = 0;
    end else begin
      p = 0;
      for (int i = 0; i < 64; i++) if (mag[i]) p = i;
      prec = sgl ? 24 : 53;
      inexact = 0; up = 0;
      if (p < prec) begin
        kept = mag;
      end else begin
        drop = p - prec + 1;
        kept = mag >> drop;
        rem  = mag & ((64'd1 << drop) - 1);
        half = 64'd1 << (drop - 1);
        inexact = (rem != 0);
        case (rm)
          2'b00: up = (rem > half) || (rem == half && kept[0]);
          2'b01: up = 0;
          2'b10: up = !neg && inexact;
          default: up = neg && inexact;
        endcase
        if (up) kept = kept + 1;
        if (kept == (64'd1 << prec)) begin kept = kept >> 1; p = p + 1; end
      end
      if (p < prec) kept = mag << (prec - 1 - p);
      frac = sgl ? {kept[22:0], 29'b0} : kept[51:0];
      e.res = {neg, 11'(p + 1023), frac};
      e.cls = neg ? 5'b01000 : 5'b00100;
      e.rnd = up; e.inx = inexact;
    end
    if (!e.upd) begin e.cls = 0; e.rnd = 0; e.inx = 0; end
    return e;
  endfunction

  task automatic drive(input logic [63:0] d, input logic [1:0] t,
                       input logic sgl, input logic [1:0] rm);
    @(negedge clk);
    srcData = d; srcType = t; singleMode = sgl; rndMode = rm; inValid = 1'b1;
  endtask

  task automatic sendExp(input logic [63:0] d, input logic [1:0] t, input logic sgl,
                         input logic [1:0] rm, input logic [63:0] res, input logic [4:0] cls,
                         input logic rnd, input logic inx, input logic upd, input string tag);
    item_t e;
    e.res = res; e.cls = cls; e.rnd = rnd; e.inx = inx; e.upd = upd; e.tag = tag;
    drive(d, t, sgl, rm);
    sbq.push_back(e);
  endtask

  task automatic sendRef(input logic [63:0] d, input logic [1:0] t,
                         input logic sgl, input logic [1:0] rm);
    item_t e;
    e = refModel(d, t, sgl, rm);
    drive(d, t, sgl, rm);
    sbq.push_back(e);
  endtask

  // monitor: compare on the falling edge after the result is registered
  always @(negedge clk) begin
    if (rstN && outValid) begin
      item_t e;
      compared++;
      if (sbq.size() == 0) begin
        mismatched++;
        $display("FAIL R9 unexpected outValid: actual 1 expected 0");
      end else begin
        e = sbq.pop_front();
        if (result !== e.res || classCode !== e.cls || fracRounded !== e.rnd ||
            fracInexact !== e.inx || inexactSet !== e.inx || statusUpdate !== e.upd) begin
          mismatched++;
          $display("FAIL %s: actual res=%h cls=%b rnd=%b inx=%b set=%b upd=%b expected res=%h cls=%b rnd=%b inx=%b set=%b upd=%b",
                   e.tag, result, classCode, fracRounded, fracInexact, inexactSet, statusUpdate,
                   e.res, e.cls, e.rnd, e.inx, e.inx, e.upd);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    compared++;
    if (outValid !== 1'b0 || result !== 64'h0 || statusUpdate !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 reset: actual v=%b res=%h upd=%b expected v=0 res=0 upd=0",
               outValid, result, statusUpdate);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3 zero
    sendExp(64'h0, 2'd3, 0, 2'b00, 64'h0, 5'b00010, 0, 0, 1, "R3 zero");
    // R4 R2 narrow signed -1 to double, no status
    sendExp(64'h0000_0000_FFFF_FFFF, 2'd0, 0, 2'b00, 64'hBFF0_0000_0000_0000, 5'b0, 0, 0, 0, "R4 R2 si32 -1");
    // R1 upper half ignored for narrow unsigned
    sendExp(64'hDEAD_BEEF_0000_0001, 2'd1, 0, 2'b10, 64'h3FF0_0000_0000_0000, 5'b0, 0, 0, 0, "R1 upper ignored");
    // R10 carry to 2^64
    sendExp(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'b00, 64'h43F0_0000_0000_0000, 5'b00100, 1, 1, 1, "R10 carry");
    // R7 toward zero
    sendExp(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'b01, 64'h43EF_FFFF_FFFF_FFFF, 5'b00100, 0, 1, 1, "R7 rz");
    // R6 R10 single carry
    sendExp(64'h0000_0000_FFFF_FFFF, 2'd1, 1, 2'b00, 64'h41F0_0000_0000_0000, 5'b00100, 1, 1, 1, "R6 R10 single");
    // R6 single toward zero
    sendExp(64'h0000_0000_FFFF_FFFF, 2'd1, 1, 2'b01, 64'h41EF_FFFF_E000_0000, 5'b00100, 0, 1, 1, "R6 single rz");
    // R2 R5 most negative 64-bit
    sendExp(64'h8000_0000_0000_0000, 2'd2, 0, 2'b00, 64'hC3E0_0000_0000_0000, 5'b01000, 0, 0, 1, "R2 R5 min");
    // R7 tie to even, toward +inf, toward -inf on a negative value
    sendExp(64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 0, 2'b00, 64'hC340_0000_0000_0000, 5'b01000, 0, 1, 1, "R7 tie even");
    sendExp(64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 0, 2'b10, 64'hC340_0000_0000_0000, 5'b01000, 0, 1, 1, "R7 up neg");
    sendExp(64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 0, 2'b11, 64'hC340_0000_0000_0001, 5'b01000, 1, 1, 1, "R7 R8 down neg");
    // R7 R8 tie rounds up to even
    sendExp(64'h0020_0000_0000_0003, 2'd3, 0, 2'b00, 64'h4340_0000_0000_0002, 5'b00100, 1, 1, 1, "R7 R8 tie odd");
    // R5 exact single results
    sendExp(64'h0000_0000_0000_0001, 2'd0, 1, 2'b00, 64'h3FF0_0000_0000_0000, 5'b00100, 0, 0, 1, "R5 si32 1 single");
    sendExp(64'h1234_5678_FFFF_FFFF, 2'd0, 1, 2'b11, 64'hBFF0_0000_0000_0000, 5'b01000, 0, 0, 1, "R5 R1 si32 -1 single");

    for (int i = 0; i < 600; i++) begin
      logic [63:0] d;
      int k;
      case ($urandom_range(0, 3))
        0: d = {$urandom(), $urandom()};
        1: d = 64'($urandom_range(0, 255));
        2: begin k = $urandom_range(20, 63); d = (64'd1 << k) + 64'($urandom_range(0, 7)); end
        default: begin k = $urandom_range(0, 63); d = {$urandom(), $urandom()} >> k; end
      endcase
      if ($urandom_range(0, 7) == 0) d = -d;
      sendRef(d, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
    end

    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    // R9 outputs hold with no strobe
    compared++;
    if (outValid !== 1'b0 || sbq.size() != 0) begin
      mismatched++;
      $display("FAIL R9 drain: actual v=%b left=%0d expected v=0 left=0", outValid, sbq.size());
    end
    allDone = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!allDone) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule